// File: doc/BRIEF.md
# Error Pin Assertion Controller

This block drives an active-low error output that tells an external supervisor that the chip needs attention. It combines a vector of raw error events with a per-event pin-enable mask. Any enabled event that is set counts as pending, and a pending event pulls the pin low. Once the pin is low, it stays low for at least a programmed minimum interval. That interval is measured in ticks of a prescaler, and later errors never restart it.

Releasing the pin takes two things: a software CLEAR strobe, and a check at that moment that no error is still pending. These may happen in either order relative to the expiry of the interval. Software can also force the pin low through the same key input. A global soft reset returns the block to idle. Only the power-on reset fully reinitialises the block, and while it is active the pin is held low.

The block sits behind a register file, which supplies the mask, the interval settings and the key strobes. Its outputs are the pin level, a status bit that marks an assertion caused by an error, and the state code.

Top module: `err_pin_ctrl`

## Requirements
- R1: With `enable_i` high, an event whose raw bit and pin-enable bit are both 1 moves the block from IDLE to ERROR on the next clock edge. The pin then reads 0 and the status reads 1.
- R2: While in IDLE, the block stays in IDLE with the pin at 1 in two cases: a raw event whose pin-enable bit is 0, and a pending event while `enable_i` is 0.
- R3: On entry to ERROR the interval counter loads `min_cnt_i` and counts down once every `prescale_i`+1 cycles, so it expires `min_cnt_i`*(`prescale_i`+1) cycles after entry. A CLEAR before expiry with nothing pending moves the block to WAIT, and the pin stays 0. WAIT moves to IDLE on the edge after expiry.
- R4: A CLEAR after expiry with nothing pending moves the block from ERROR to IDLE on the next edge, and the pin returns to 1.
- R5: A CLEAR while an error is still pending leaves the block in ERROR. Without a CLEAR, the block never leaves ERROR, even after the error has gone and the interval has expired. A single later CLEAR releases the pin after several earlier errors.
- R6: New errors that arrive while in ERROR do not reload the interval counter.
- R7: A pending error in WAIT returns the block to ERROR without reloading the counter, and a fresh CLEAR is then needed.
- R8: Key writes use `key_i` values 0xA = force, 0x0 = normal and 0x5 = CLEAR. The force mode holds the pin at 0 until a normal write, and it does not change the state or the status. Any other value, including CLEAR, leaves the mode unchanged.
- R9: `soft_rst_i` moves the block to IDLE on the next edge from any state. It also clears the interval counter and the force mode, so the pin reads 1.
- R10: While `rst_ni` is low, the state is RESET, the pin reads 0 and the status reads 0. On the first edge after release, the block moves to IDLE with the pin at 1.
- R11: `state_o` encodes RESET=0, IDLE=1, ERROR=2 and WAIT=3. `pin_sts_o` is 1 exactly in ERROR and WAIT.
- R12: With `min_cnt_i`=0 the interval has already expired on entry, so a CLEAR with nothing pending returns the block from ERROR straight to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst_i | input | 1 | Global soft reset, synchronous |
| enable_i | input | 1 | Global enable for new assertions from IDLE |
| evt_raw_i | input | N_EVT | Raw error event bits |
| evt_pin_en_i | input | N_EVT | Per-event pin-enable mask |
| min_cnt_i | input | CNT_W | Minimum interval in ticks |
| prescale_i | input | PRE_W | Tick period minus one, in cycles |
| key_wr_i | input | 1 | Key write strobe |
| key_i | input | 4 | Key value written |
| err_n_o | output | 1 | Error pin, active low |
| pin_sts_o | output | 1 | Pin asserted by an error |
| state_o | output | 2 | Current state code |

## Verification
A wrong state shows up at `state_o` and `err_n_o` on the very next edge after the stimulus, because both are decoded directly from registered state. A counter that is wrongly reloaded or mistimed shows up only at expiry: the release from WAIT arrives late or early against a count taken from the entry edge. The bench therefore checks the cycle of release in the WAIT paths that follow a late error and a re-entry from WAIT. A force mode or CLEAR memory left in the wrong state shows up as a pin that stays low when the state code reads IDLE, or as a release without a fresh CLEAR.

// File: rtl/err_pin_pkg.sv
package err_pin_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_IDLE  = 2'd1,
    ST_ERROR = 2'd2,
    ST_WAIT  = 2'd3
  } pin_state_e;

  localparam int KEY_W = 4;
  localparam logic [KEY_W-1:0] KEY_NORMAL = 4'h0;
  localparam logic [KEY_W-1:0] KEY_FORCE  = 4'hA;
  localparam logic [KEY_W-1:0] KEY_CLEAR  = 4'h5;
endpackage

// File: rtl/err_pin_prescaler.sv
module err_pin_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/err_pin_interval.sv
module err_pin_interval #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (tick_i && !expired_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/err_pin_fsm.sv
module err_pin_fsm
  import err_pin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       enable_i,
  input  logic       pending_i,
  input  logic       clear_i,
  input  logic       expired_i,
  output pin_state_e state_o,
  output logic       load_o
);
  pin_state_e state_q, state_d;

  assign state_o = state_q;
  assign load_o  = (state_q == ST_IDLE) && enable_i && pending_i && !soft_rst_i;

  always_comb begin
    state_d = state_q;
    if (soft_rst_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_RESET: state_d = ST_IDLE;
        ST_IDLE:  if (enable_i && pending_i) state_d = ST_ERROR;
        // CLEAR is consumed here; pending at that moment keeps ERROR
        ST_ERROR: if (clear_i && !pending_i) state_d = expired_i ? ST_IDLE : ST_WAIT;
        ST_WAIT: begin
          if (pending_i)      state_d = ST_ERROR;
          else if (expired_i) state_d = ST_IDLE;
        end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/err_pin_ctrl.sv
module err_pin_ctrl
  import err_pin_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             enable_i,
  input  logic [N_EVT-1:0] evt_raw_i,
  input  logic [N_EVT-1:0] evt_pin_en_i,
  input  logic [CNT_W-1:0] min_cnt_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic             key_wr_i,
  input  logic [3:0]       key_i,
  output logic             err_n_o,
  output logic             pin_sts_o,
  output logic [1:0]       state_o
);
  logic [N_EVT-1:0] hit;
  logic             pending;
  logic             clear_stb;
  logic             force_q;
  logic             load;
  logic             tick;
  logic             expired;
  pin_state_e       state;

  for (genvar i = 0; i < N_EVT; i++) begin : g_hit
    assign hit[i] = evt_raw_i[i] & evt_pin_en_i[i];
  end
  assign pending = |hit;

  assign clear_stb = key_wr_i && (key_i == KEY_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               force_q <= 1'b0;
    else if (soft_rst_i)                       force_q <= 1'b0;
    else if (key_wr_i && key_i == KEY_FORCE)   force_q <= 1'b1;
    else if (key_wr_i && key_i == KEY_NORMAL)  force_q <= 1'b0;
  end

  err_pin_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (load),
    .prescale_i (prescale_i),
    .tick_o     (tick)
  );

  err_pin_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst_i),
    .load_i     (load),
    .load_val_i (min_cnt_i),
    .tick_i     (tick),
    .expired_o  (expired)
  );

  err_pin_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .enable_i   (enable_i),
    .pending_i  (pending),
    .clear_i    (clear_stb),
    .expired_i  (expired),
    .state_o    (state),
    .load_o     (load)
  );

  assign pin_sts_o = (state == ST_ERROR) || (state == ST_WAIT);
  assign err_n_o   = !(pin_sts_o || (state == ST_RESET) || force_q);
  assign state_o   = state;
endmodule

// File: rtl/err_pin_ctrl_chk.sv
module err_pin_ctrl_chk
  import err_pin_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       enable_i,
  input logic       pending,
  input logic       clear_stb,
  input logic       expired,
  input logic       key_wr_i,
  input logic [3:0] key_i,
  input logic       err_n_o,
  input logic [1:0] state_o
);
  assert_enter_error_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && enable_i && pending && !soft_rst_i) |=> (state_o == ST_ERROR && !err_n_o));

  assert_min_time_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == ST_ERROR || state_o == ST_WAIT) && !expired && !soft_rst_i) |=> !err_n_o);

  assert_late_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ERROR && clear_stb && !pending && expired && !soft_rst_i) |=> (state_o == ST_IDLE));

  assert_hold_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ERROR && pending && !soft_rst_i) |=> (state_o == ST_ERROR));

  assert_wait_reenter_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_WAIT && pending && !soft_rst_i) |=> (state_o == ST_ERROR));

  assert_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && key_i == KEY_FORCE && !soft_rst_i) |=> !err_n_o);

  assert_soft_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (state_o == ST_IDLE && err_n_o));
endmodule

bind err_pin_ctrl err_pin_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .enable_i   (enable_i),
  .pending    (pending),
  .clear_stb  (clear_stb),
  .expired    (expired),
  .key_wr_i   (key_wr_i),
  .key_i      (key_i),
  .err_n_o    (err_n_o),
  .state_o    (state_o)
);

// File: tb/err_pin_ctrl_test.sv
module err_pin_ctrl_test;
  localparam int N_EVT = 8;
  localparam int CNT_W = 16;
  localparam int PRE_W = 8;
  localparam logic [1:0] S_RST = 2'd0, S_IDLE = 2'd1, S_ERR = 2'd2, S_WAIT = 2'd3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             soft_rst_i = 1'b0;
  logic             enable_i = 1'b1;
  logic [N_EVT-1:0] evt_raw_i = '0;
  logic [N_EVT-1:0] evt_pin_en_i = 8'h03;
  logic [CNT_W-1:0] min_cnt_i = 16'd4;
  logic [PRE_W-1:0] prescale_i = 8'd1;
  logic             key_wr_i = 1'b0;
  logic [3:0]       key_i = 4'h0;
  logic             err_n_o;
  logic             pin_sts_o;
  logic [1:0]       state_o;

  typedef struct {
    int         due;
    logic       pin;
    logic       sts;
    logic [1:0] st;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  err_pin_ctrl #(.N_EVT(N_EVT), .CNT_W(CNT_W), .PRE_W(PRE_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .enable_i(enable_i),
    .evt_raw_i(evt_raw_i), .evt_pin_en_i(evt_pin_en_i), .min_cnt_i(min_cnt_i),
    .prescale_i(prescale_i), .key_wr_i(key_wr_i), .key_i(key_i),
    .err_n_o(err_n_o), .pin_sts_o(pin_sts_o), .state_o(state_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    exp_t it;
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      n_run++;
      if (err_n_o !== it.pin || pin_sts_o !== it.sts || state_o !== it.st) begin
        n_fail++;
        $display("FAIL %s: pin/sts/state = %b/%b/%0d, expected %b/%b/%0d",
                 it.tag, err_n_o, pin_sts_o, state_o, it.pin, it.sts, it.st);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_in(input int k, input logic pin, input logic sts,
                           input logic [1:0] st, input string tag);
    exp_t it;
    it.due = cyc + k; it.pin = pin; it.sts = sts; it.st = st; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic key_pulse(input logic [3:0] v);
    key_i = v; key_wr_i = 1'b1;
    step(1);
    key_wr_i = 1'b0; key_i = 4'h0;
  endtask

  initial begin
    step(1);
    expect_in(1, 1'b0, 1'b0, S_RST, "R10 during POR");
    step(1);
    rst_ni = 1'b1;
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R10 R11 after POR");
    step(1);

    // R1 / R3: clear inside interval, release on edge after expiry
    evt_raw_i = 8'h01;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R1 enter error");
    step(1);
    evt_raw_i = 8'h00;
    expect_in(1, 1'b0, 1'b1, S_WAIT, "R3 clear in interval");
    expect_in(8, 1'b0, 1'b1, S_WAIT, "R3 held until expiry");
    expect_in(9, 1'b1, 1'b0, S_IDLE, "R3 release after expiry");
    key_pulse(4'h5);
    step(8);

    // R2: masked event, then disabled block
    evt_raw_i = 8'h04;
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R2 masked event");
    expect_in(3, 1'b1, 1'b0, S_IDLE, "R2 masked event later");
    step(3);
    enable_i = 1'b0;
    evt_raw_i = 8'h01;
    expect_in(2, 1'b1, 1'b0, S_IDLE, "R2 enable low");
    step(2);
    enable_i = 1'b1;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R1 on enable");
    step(1);
    evt_raw_i = 8'h00;
    expect_in(10, 1'b0, 1'b1, S_ERR, "R5 no release without clear");
    step(10);
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R4 clear after expiry");
    key_pulse(4'h5);

    // R5: clear while pending stays in error
    evt_raw_i = 8'h01;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R5 enter");
    step(10);
    expect_in(1, 1'b0, 1'b1, S_ERR, "R5 clear while pending");
    expect_in(2, 1'b0, 1'b1, S_ERR, "R5 still error");
    key_pulse(4'h5);
    step(1);
    evt_raw_i = 8'h00;
    expect_in(3, 1'b0, 1'b1, S_ERR, "R5 needs another clear");
    step(3);
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R5 single clear releases");
    key_pulse(4'h5);

    // R6: later error in ERROR does not restart the interval
    evt_raw_i = 8'h01;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R6 enter");
    step(1);
    step(5);
    evt_raw_i = 8'h02;
    step(1);
    evt_raw_i = 8'h00;
    expect_in(1, 1'b0, 1'b1, S_WAIT, "R6 clear to wait");
    key_pulse(4'h5);
    expect_in(1, 1'b0, 1'b1, S_WAIT, "R6 wait before expiry");
    expect_in(2, 1'b1, 1'b0, S_IDLE, "R6 no counter restart");
    step(2);

    // R7: new error in WAIT returns to ERROR, no restart
    evt_raw_i = 8'h01;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R7 enter");
    step(1);
    evt_raw_i = 8'h00;
    expect_in(1, 1'b0, 1'b1, S_WAIT, "R7 to wait");
    key_pulse(4'h5);
    step(2);
    evt_raw_i = 8'h02;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R7 back to error");
    step(1);
    evt_raw_i = 8'h00;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R7 fresh clear needed");
    step(1);
    expect_in(1, 1'b0, 1'b1, S_WAIT, "R7 second clear");
    key_pulse(4'h5);
    expect_in(2, 1'b0, 1'b1, S_WAIT, "R7 wait before expiry");
    expect_in(3, 1'b1, 1'b0, S_IDLE, "R7 no counter restart");
    step(3);

    // R8: force / clear / normal keys
    expect_in(1, 1'b0, 1'b0, S_IDLE, "R8 force");
    key_pulse(4'hA);
    expect_in(3, 1'b0, 1'b0, S_IDLE, "R8 force held");
    step(3);
    expect_in(1, 1'b0, 1'b0, S_IDLE, "R8 clear keeps force");
    key_pulse(4'h5);
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R8 normal");
    key_pulse(4'h0);

    // R9: soft reset from ERROR with force set
    evt_raw_i = 8'h01;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R9 enter");
    step(1);
    evt_raw_i = 8'h00;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R8 force keeps status");
    key_pulse(4'hA);
    soft_rst_i = 1'b1;
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R9 soft reset");
    step(1);
    soft_rst_i = 1'b0;
    expect_in(2, 1'b1, 1'b0, S_IDLE, "R9 force cleared");
    step(2);

    // R12: zero minimum interval
    min_cnt_i = 16'd0;
    evt_raw_i = 8'h01;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R12 enter");
    step(1);
    evt_raw_i = 8'h00;
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R12 immediate release");
    key_pulse(4'h5);
    min_cnt_i = 16'd4;

    // R10: power-on reset during ERROR
    evt_raw_i = 8'h01;
    expect_in(1, 1'b0, 1'b1, S_ERR, "R10 enter");
    step(1);
    expect_in(1, 1'b0, 1'b0, S_RST, "R10 POR in error");
    #2 rst_ni = 1'b0;
    evt_raw_i = 8'h00;
    step(1);
    rst_ni = 1'b1;
    expect_in(1, 1'b1, 1'b0, S_IDLE, "R10 release");
    step(1);

    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule